// File: doc/BRIEF.md
# Single-Precision Round-to-Integral Unit

This block takes one IEEE-754 binary32 operand and rounds it to the nearest integral value in one of five rounding directions. The result is still a binary32 value, not an integer, so a large magnitude never saturates. The direction comes from a 3-bit static code, or from a separate dynamic-mode input when the static code selects it. Zeros, infinities and operands that are already integral come back bit-for-bit. Any NaN comes back as the canonical quiet NaN. The only exception the unit ever reports is invalid-operation, and only for a signaling NaN. Inexact is never raised, even when rounding changes the value.

A request is a single-cycle `in_valid` strobe that carries the operand and the two mode inputs. With `REGISTERED=1` every result appears exactly one cycle later, whatever the operand. With `REGISTERED=0` the result follows the request in the same cycle. Mode codes the unit does not define produce no result. Instead they raise an illegal-mode indication and force the result to positive zero.

Top module: `fp_rint`

## Requirements
- R1: A finite, nonzero operand whose biased exponent is below 150 is rounded to an integral value in the selected direction and returned as binary32 (for example 2.5 gives 2.0 under nearest-even and 3.0 under toward-plus).
- R2: Mode codes are: 000 nearest with ties to even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 nearest with ties away from zero.
- R3: Static code 111 selects the rounding direction from `dyn_rm`, which uses the codes of R2.
- R4: Static code 101 or 110, or static code 111 with `dyn_rm` of 101, 110 or 111, is illegal. The result then has `out_illegal`=1, `out_res`=0x00000000 and `out_flags`=0, even for a NaN operand.
- R5: +0, -0, +infinity and -infinity pass to `out_res` unchanged.
- R6: Any NaN, quiet or signaling, gives 0x7FC00000. A NaN is exponent 0xFF with a nonzero fraction, and it is signaling when fraction bit 22 is 0.
- R7: `out_flags` bit 4 is invalid-operation and is set only for a signaling NaN under a legal mode. Bits 3..0, including inexact in bit 0, are always 0.
- R8: An operand whose biased exponent is 150 to 254 is returned unchanged.
- R9: A nonzero operand that rounds to zero returns a zero carrying the operand's sign (-0.3 under nearest-even gives 0x80000000).
- R10: Halfway cases go to the even neighbour under code 000 (1.5 and 2.5 give 2.0, 3.5 gives 4.0) and away from zero under code 100.
- R11: Subnormal operands round to ±0 or ±1.0 according to the direction and the sign.
- R12: With `REGISTERED=1`, `out_valid` is high exactly one cycle after each `in_valid` and low otherwise, for every operand. `out_valid`, `out_res`, `out_flags` and `out_illegal` reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | EXP_W+MAN_W+1 | Operand, binary32 with the defaults |
| in_rm | input | 3 | Static rounding-mode code |
| dyn_rm | input | 3 | Dynamic rounding-mode code, used when `in_rm` is 111 |
| out_valid | output | 1 | Result strobe |
| out_res | output | EXP_W+MAN_W+1 | Rounded result |
| out_flags | output | 5 | Exception flags, bit 4 invalid |
| out_illegal | output | 1 | Illegal rounding mode for this result |

## Verification
The bench builds the unit with its default parameters: an 8-bit exponent, a 23-bit fraction and the registered variant. This puts the true binary32 cases within reach. These are the 150 threshold where every value is already integral, the largest non-integral value (8388607.5) carrying into the next binade, subnormal operands, and the fixed one-cycle latency of R12. Operands with random exponents from 100 to 158 are checked under every legal mode against a model that decodes the operand to a real number and rounds it with floor and ceiling. Directed vectors cover halfway ties, signed zeros, NaN flavours and the illegal mode codes.

// File: rtl/fp_rint_pkg.sv
package fp_rint_pkg;

   typedef enum logic [2:0] {
      RM_NEAR_EVEN = 3'b000,
      RM_ZERO      = 3'b001,
      RM_DOWN      = 3'b010,
      RM_UP        = 3'b011,
      RM_NEAR_MAX  = 3'b100
   } rnd_mode_e;

   localparam logic [2:0] RM_FROM_DYN = 3'b111;
   localparam int FLAGS_W = 5;
   localparam int FLG_NV  = 4;

endpackage

// File: rtl/fp_rint_mode.sv
module fp_rint_mode
   import fp_rint_pkg::*;
(
   input  logic [2:0] rm,
   input  logic [2:0] dyn,
   output rnd_mode_e  mode,
   output logic       illegal
);

   logic [2:0] eff;

   always_comb begin
      eff     = (rm == RM_FROM_DYN) ? dyn : rm;
      illegal = (eff > 3'b100);
      if (illegal) mode = RM_NEAR_EVEN;
      else         mode = rnd_mode_e'(eff);
   end

endmodule

// File: rtl/fp_rint_class.sv
module fp_rint_class #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] op,
   output logic                 is_zero,
   output logic                 is_inf,
   output logic                 is_nan,
   output logic                 is_snan,
   output logic                 is_whole
);

   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int INT_THR = BIAS + MAN_W;

   logic [EXP_W-1:0] e;
   logic [MAN_W-1:0] f;
   logic             e_max;

   always_comb begin
      e        = op[EXP_W+MAN_W-1:MAN_W];
      f        = op[MAN_W-1:0];
      e_max    = &e;
      is_zero  = (e == '0) && (f == '0);
      is_inf   = e_max && (f == '0);
      is_nan   = e_max && (f != '0);
      is_snan  = is_nan && !f[MAN_W-1];
      is_whole = !e_max && (int'(e) >= INT_THR);
   end

endmodule

// File: rtl/fp_rint_msb.sv
module fp_rint_msb #(
   parameter int N  = 25,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          found
);

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) idx = IW'(i);
      end
      found = |vec;
   end

endmodule

// File: rtl/fp_rint_core.sv
module fp_rint_core
   import fp_rint_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                 sign,
   input  logic [EXP_W-1:0]     exp_f,
   input  logic [MAN_W-1:0]     man,
   input  rnd_mode_e            mode,
   output logic [EXP_W+MAN_W:0] res
);

   localparam int SIG_W   = MAN_W + 1;
   localparam int IR_W    = SIG_W + 1;
   localparam int IDX_W   = $clog2(IR_W);
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int INT_THR = BIAS + MAN_W;

   logic [SIG_W-1:0] sig, ipart, low_mask, gtmp;
   logic             guard, sticky, bump;
   logic [IR_W-1:0]  mag, shifted;
   logic [IDX_W-1:0] top;
   logic             nz;
   int               fb, shamt;

   // split the significand into integer part, guard bit and sticky bit
   always_comb begin
      sig      = {exp_f != '0, man};
      fb       = INT_THR - int'(exp_f);
      low_mask = '0;
      gtmp     = '0;
      if (int'(exp_f) < BIAS - 1) begin
         ipart  = '0;
         guard  = 1'b0;
         sticky = |sig;
      end else if (fb <= 0) begin
         ipart  = sig;
         guard  = 1'b0;
         sticky = 1'b0;
      end else begin
         ipart    = sig >> fb;
         gtmp     = sig >> (fb - 1);
         guard    = gtmp[0];
         low_mask = (SIG_W'(1) << (fb - 1)) - SIG_W'(1);
         sticky   = |(sig & low_mask);
      end
      case (mode)
         RM_NEAR_EVEN: bump = guard & (sticky | ipart[0]);
         RM_NEAR_MAX:  bump = guard;
         RM_ZERO:      bump = 1'b0;
         RM_DOWN:      bump = sign & (guard | sticky);
         RM_UP:        bump = ~sign & (guard | sticky);
         default:      bump = 1'b0;
      endcase
      mag = {1'b0, ipart} + IR_W'(bump);
   end

   fp_rint_msb #(.N(IR_W), .IW(IDX_W)) u_msb (
      .vec   (mag),
      .idx   (top),
      .found (nz)
   );

   // repack the integer magnitude as a normal number
   always_comb begin
      shamt = MAN_W - int'(top);
      if (shamt < 0) shamt = 0;
      shifted = mag << shamt;
      if (!nz) res = {sign, {(EXP_W + MAN_W){1'b0}}};
      else     res = {sign, EXP_W'(BIAS + int'(top)), shifted[MAN_W-1:0]};
   end

endmodule

// File: rtl/fp_rint.sv
module fp_rint
   import fp_rint_pkg::*;
#(
   parameter int EXP_W      = 8,
   parameter int MAN_W      = 23,
   parameter bit REGISTERED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [EXP_W+MAN_W:0] in_op,
   input  logic [2:0]           in_rm,
   input  logic [2:0]           dyn_rm,
   output logic                 out_valid,
   output logic [EXP_W+MAN_W:0] out_res,
   output logic [4:0]           out_flags,
   output logic                 out_illegal
);

   localparam int W       = EXP_W + MAN_W + 1;
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int INT_THR = BIAS + MAN_W;
   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W - 1){1'b0}}};

   generate
      if (EXP_W < 3 || MAN_W < 2) begin : g_bad_width
         $error("fp_rint: EXP_W must be >= 3 and MAN_W >= 2");
      end
      if (INT_THR >= (1 << EXP_W) - 1) begin : g_bad_range
         $error("fp_rint: exponent range cannot hold every integral value");
      end
      if (FLAGS_W != 5) begin : g_bad_flags
         $error("fp_rint: flag vector must be 5 bits");
      end
   endgenerate

   rnd_mode_e      mode;
   logic           illegal;
   logic           is_zero, is_inf, is_nan, is_snan, is_whole;
   logic [W-1:0]   core_res;
   logic [W-1:0]   c_res;
   logic [4:0]     c_flags;

   fp_rint_mode u_mode (
      .rm      (in_rm),
      .dyn     (dyn_rm),
      .mode    (mode),
      .illegal (illegal)
   );

   fp_rint_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
      .op       (in_op),
      .is_zero  (is_zero),
      .is_inf   (is_inf),
      .is_nan   (is_nan),
      .is_snan  (is_snan),
      .is_whole (is_whole)
   );

   fp_rint_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_core (
      .sign  (in_op[W-1]),
      .exp_f (in_op[W-2:MAN_W]),
      .man   (in_op[MAN_W-1:0]),
      .mode  (mode),
      .res   (core_res)
   );

   always_comb begin
      c_flags = '0;
      if (illegal) begin
         c_res = '0;
      end else if (is_nan) begin
         c_res           = QNAN;
         c_flags[FLG_NV] = is_snan;
      end else if (is_zero || is_inf || is_whole) begin
         c_res = in_op;
      end else begin
         c_res = core_res;
      end
   end

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid   <= 1'b0;
               out_res     <= '0;
               out_flags   <= '0;
               out_illegal <= 1'b0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  out_res     <= c_res;
                  out_flags   <= c_flags;
                  out_illegal <= illegal;
               end
            end
         end

         AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);                                     // R12
         AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);                                   // R12
      end else begin : g_comb
         always_comb begin
            out_valid   = in_valid;
            out_res     = c_res;
            out_flags   = c_flags;
            out_illegal = illegal;
         end
      end
   endgenerate

   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_rm == 3'b101 || in_rm == 3'b110))
      |-> (illegal && c_res == '0 && c_flags == '0));                    // R4
   AST_NV_ONLY_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && c_flags[FLG_NV])
      |-> ((&in_op[W-2:MAN_W]) && !in_op[MAN_W-1] && in_op[MAN_W-2:0] != '0)); // R7
   AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !illegal && (&in_op[W-2:MAN_W]) && in_op[MAN_W-1:0] != '0)
      |-> (c_res == QNAN));                                              // R6
   AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !illegal && in_op[W-2:0] == '0) |-> (c_res == in_op)); // R5
   AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !illegal && !(&in_op[W-2:MAN_W]))
      |-> (core_res[W-1] == in_op[W-1]));                                // R9

endmodule

// File: tb/tb_fp_rint.sv
module tb_fp_rint;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_op = '0;
   logic [2:0]  in_rm = '0;
   logic [2:0]  dyn_rm = '0;
   logic        out_valid;
   logic [31:0] out_res;
   logic [4:0]  out_flags;
   logic        out_illegal;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   fp_rint dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
      .in_rm (in_rm), .dyn_rm (dyn_rm), .out_valid (out_valid),
      .out_res (out_res), .out_flags (out_flags), .out_illegal (out_illegal)
   );

   // {operand, rm, dyn, expected result, expected flags, expected illegal}
   localparam int NV = 26;
   localparam logic [75:0] VEC [NV] = '{
      {32'h40200000, 3'b000, 3'b000, 32'h40000000, 5'h00, 1'b0}, // R10 2.5 even
      {32'h40600000, 3'b000, 3'b000, 32'h40800000, 5'h00, 1'b0}, // R10 3.5 even
      {32'h40200000, 3'b100, 3'b000, 32'h40400000, 5'h00, 1'b0}, // R10 2.5 away
      {32'h40200000, 3'b001, 3'b000, 32'h40000000, 5'h00, 1'b0}, // R2 zero
      {32'h40200000, 3'b011, 3'b000, 32'h40400000, 5'h00, 1'b0}, // R2 up
      {32'h40200000, 3'b010, 3'b000, 32'h40000000, 5'h00, 1'b0}, // R2 down
      {32'hC0200000, 3'b010, 3'b000, 32'hC0400000, 5'h00, 1'b0}, // R2 -2.5 down
      {32'hC0200000, 3'b011, 3'b000, 32'hC0000000, 5'h00, 1'b0}, // R2 -2.5 up
      {32'hBE99999A, 3'b000, 3'b000, 32'h80000000, 5'h00, 1'b0}, // R9 -0.3
      {32'h3F000000, 3'b000, 3'b000, 32'h00000000, 5'h00, 1'b0}, // R10 0.5 even
      {32'h3F000000, 3'b100, 3'b000, 32'h3F800000, 5'h00, 1'b0}, // R10 0.5 away
      {32'hBF000000, 3'b011, 3'b000, 32'h80000000, 5'h00, 1'b0}, // R9 -0.5 up
      {32'hBE99999A, 3'b010, 3'b000, 32'hBF800000, 5'h00, 1'b0}, // R1 -0.3 down
      {32'h3F333333, 3'b001, 3'b000, 32'h00000000, 5'h00, 1'b0}, // R9 0.7 zero
      {32'h3F333333, 3'b000, 3'b000, 32'h3F800000, 5'h00, 1'b0}, // R1 0.7 nearest
      {32'h00000001, 3'b011, 3'b000, 32'h3F800000, 5'h00, 1'b0}, // R11 subnormal up
      {32'h00000001, 3'b000, 3'b000, 32'h00000000, 5'h00, 1'b0}, // R11 subnormal even
      {32'h80000001, 3'b010, 3'b000, 32'hBF800000, 5'h00, 1'b0}, // R11 neg subnormal down
      {32'h4AFFFFFF, 3'b000, 3'b000, 32'h4B000000, 5'h00, 1'b0}, // R1 carry to next binade
      {32'h4AFFFFFF, 3'b001, 3'b000, 32'h4AFFFFFE, 5'h00, 1'b0}, // R1 truncate
      {32'h4B000001, 3'b011, 3'b000, 32'h4B000001, 5'h00, 1'b0}, // R8 exp 150
      {32'hCF000000, 3'b010, 3'b000, 32'hCF000000, 5'h00, 1'b0}, // R8 large negative
      {32'h40200000, 3'b111, 3'b011, 32'h40400000, 5'h00, 1'b0}, // R3 dyn up
      {32'h3FC00000, 3'b000, 3'b000, 32'h40000000, 5'h00, 1'b0}, // R10 1.5 even
      {32'hBFC00000, 3'b100, 3'b000, 32'hC0000000, 5'h00, 1'b0}, // R10 -1.5 away
      {32'h40200000, 3'b111, 3'b100, 32'h40400000, 5'h00, 1'b0}  // R3 dyn away
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] op, input logic [2:0] rm, input logic [2:0] dyn);
      @(negedge clk);
      in_op = op; in_rm = rm; dyn_rm = dyn; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [31:0] ref_round(input logic [31:0] op, input logic [2:0] m);
      logic [7:0]  e;
      logic [22:0] f;
      real         mag, fl, r;
      int          k, p;
      logic [31:0] t;
      e = op[30:23];
      f = op[22:0];
      if (e == 8'hFF) return (f != 0) ? 32'h7FC00000 : op;
      if (op[30:0] == 0 || e >= 8'd150) return op;
      if (e == 0) mag = real'(f) * $pow(2.0, -149.0);
      else        mag = real'(32'h00800000 + f) * $pow(2.0, real'(int'(e) - 150));
      fl = $floor(mag);
      case (m)
         3'b000: r = (mag - fl > 0.5 || (mag - fl == 0.5 && (int'(fl) % 2) == 1)) ? fl + 1.0 : fl;
         3'b100: r = (mag - fl >= 0.5) ? fl + 1.0 : fl;
         3'b001: r = fl;
         3'b010: r = op[31] ? $ceil(mag) : fl;
         default: r = op[31] ? fl : $ceil(mag);
      endcase
      k = int'(r);
      if (k == 0) return {op[31], 31'h0};
      p = 0;
      for (int i = 0; i < 31; i++) if (k[i]) p = i;
      t = 32'(k) << (23 - p);
      return {op[31], 8'(127 + p), t[22:0]};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 reset valid", 32'(out_valid), 32'h0);
      chk("R12 reset res", out_res, 32'h0);
      chk("R12 reset flags", 32'(out_flags), 32'h0);
      chk("R12 reset illegal", 32'(out_illegal), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][75:44], VEC[i][43:41], VEC[i][40:38]);
         chk($sformatf("R1 R2 table %0d valid", i), 32'(out_valid), 32'h1);
         chk($sformatf("R1 R2 table %0d res", i), out_res, VEC[i][37:6]);
         chk($sformatf("R7 table %0d flags", i), 32'(out_flags), 32'(VEC[i][5:1]));
         chk($sformatf("R4 table %0d illegal", i), 32'(out_illegal), 32'(VEC[i][0]));
      end

      // R5 zeros and infinities
      apply(32'h00000000, 3'b011, 3'b000); chk("R5 +0", out_res, 32'h00000000);
      apply(32'h80000000, 3'b010, 3'b000); chk("R5 -0", out_res, 32'h80000000);
      apply(32'h7F800000, 3'b000, 3'b000); chk("R5 +inf", out_res, 32'h7F800000);
      apply(32'hFF800000, 3'b001, 3'b000); chk("R5 -inf", out_res, 32'hFF800000);
      chk("R7 -inf flags", 32'(out_flags), 32'h0);

      // R6 and R7 NaNs
      apply(32'h7F800001, 3'b000, 3'b000);
      chk("R6 snan res", out_res, 32'h7FC00000);
      chk("R7 snan flags", 32'(out_flags), 32'h10);
      apply(32'h7FC00001, 3'b001, 3'b000);
      chk("R6 qnan res", out_res, 32'h7FC00000);
      chk("R7 qnan flags", 32'(out_flags), 32'h0);
      apply(32'hFFC00000, 3'b100, 3'b000);
      chk("R6 neg qnan res", out_res, 32'h7FC00000);

      // R4 illegal codes
      apply(32'h40200000, 3'b101, 3'b000);
      chk("R4 rm101 illegal", 32'(out_illegal), 32'h1);
      chk("R4 rm101 res", out_res, 32'h0);
      apply(32'h40200000, 3'b110, 3'b000);
      chk("R4 rm110 illegal", 32'(out_illegal), 32'h1);
      apply(32'h40200000, 3'b111, 3'b101);
      chk("R4 dyn101 illegal", 32'(out_illegal), 32'h1);
      chk("R4 dyn101 res", out_res, 32'h0);
      apply(32'h7F800001, 3'b111, 3'b111);
      chk("R4 dyn111 snan res", out_res, 32'h0);
      chk("R4 dyn111 snan flags", 32'(out_flags), 32'h0);
      apply(32'h40200000, 3'b111, 3'b000);
      chk("R3 dyn even illegal", 32'(out_illegal), 32'h0);
      chk("R3 dyn even res", out_res, 32'h40000000);

      // R12 valid drops one cycle after the strobe
      @(negedge clk);
      chk("R12 valid low after gap", 32'(out_valid), 32'h0);

      // R1 random operands against the real-number model, every mode
      void'($urandom(32'd7));
      for (int n = 0; n < 400; n++) begin
         logic [31:0] op;
         logic [2:0]  m;
         op = {1'($urandom), 8'(100 + ($urandom % 59)), 23'($urandom)};
         m  = 3'(n % 5);
         apply(op, m, 3'b000);
         chk($sformatf("R1 random op=%h m=%0d", op, m), out_res, ref_round(op, m));
         chk("R7 random flags", 32'(out_flags), 32'h0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule